// File: doc/BRIEF.md
# Start-Bit Framed Serial LCD Segment Driver

This block takes display data from a two-wire serial link, one data line and one clock line, and drives a bank of directly driven LCD segment outputs. No load strobe or select pin is used. A frame opens with a start bit of one, and the segment bits follow it. A fixed count of serial clocks then marks the end of the frame. On the rising edge of the last counted clock, the collected bits are copied into output latches. On the falling edge of that same clock, the shifter and the counter are cleared, so the next start bit can follow with no gap.

The serial clock is treated as a slow input strobe. It is sampled by a fast system clock, and both of its edges are detected synchronously. The block comes in two variants. In the enable variant, an enable input decides whether a serial clock edge counts. In the other variant, the enable is ignored and one more segment output is driven from one more frame bit.

A backplane square wave is made by toggling on each oscillator tick, which gives exactly 50% duty. Each segment output is driven in phase with the backplane when its latch bit is clear, and in antiphase when the bit is set. This keeps any DC level off the glass.

Top module: `serial_seg_driver`

## Requirements
- R1: After reset, all latch bits and the backplane are 0, so every segment output and `extraSeg` are low and the frame counter is idle.
- R2: While idle, a rising serial clock edge that samples data 0 is ignored. An edge that samples 1 is the start bit, and it is counted as clock 1 of a frame.
- R3: The latches load on the rising edge of clock FRAME_CLOCKS (36) of a frame and never earlier. After 35 clocks the outputs are unchanged, and after the rising edge of clock 36 they show the new frame.
- R4: On the falling edge of the loading clock, the shifter and the counter clear. A start bit on the very next rising edge begins a new frame, so frames may be sent back to back.
- R5: A frame that stops short of 36 clocks loads nothing, however long the pause. Later clocks continue the same count and complete that frame.
- R6: Data bit k, the k-th bit after the start bit, drives `segOut[k-1]`. Bits sampled on clocks after the last data bit and up to clock 36 are ignored.
- R7: Latched data holds until the next complete frame. Sending a frame identical to the latched data leaves every segment output unchanged throughout.
- R8: In the enable variant (HAS_ENABLE=1), rising edges seen while `dataEn` is low neither shift nor count.
- R9: The backplane, which `extraSeg` shows in the enable variant, toggles once per `oscTick` pulse and holds between pulses.
- R10: Each segment output equals the backplane when its latch bit is 0, and the inverted backplane when its latch bit is 1.
- R11: With HAS_ENABLE=0, `dataEn` has no effect. The frame then carries SEG_COUNT+1 data bits, and the last of them drives `extraSeg` under the polarity rule of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock, already synchronous to clk |
| serData | input | 1 | Serial data, sampled on serClk rising edges |
| dataEn | input | 1 | Clock acceptance enable (enable variant only) |
| oscTick | input | 1 | One-cycle oscillator pulse that toggles the backplane |
| segOut | output | SEG_COUNT | Segment drive outputs |
| extraSeg | output | 1 | Backplane (enable variant) or extra segment output |

## Verification
Directed frames with a single set bit, followed by random 33-bit patterns, show whether bit order and segment polarity are right against both backplane phases. Random back-to-back frames separate a design that clears on the falling edge from one that clears late or drops the next start bit. Frames cut off at 35 clocks or after a long pause, a run of leading zeros, and clocks given with the enable low separate correct framing from loading too early, counting idle zeros, or honouring gated clocks. A second instance without the enable checks the extra data bit and confirms that the enable input is ignored.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic clearEn;
  } strobes_t;
endpackage

// File: rtl/segdrv_ctrl.sv
module segdrv_ctrl
  import segdrv_pkg::*;
#(
  parameter int  FRAME_CLOCKS = 36,
  parameter int  SHIFT_BITS   = 32,
  parameter bit  HAS_ENABLE   = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serClk,
  input  logic     serData,
  input  logic     dataEn,
  output strobes_t strb
);
  localparam int CW = $clog2(FRAME_CLOCKS + 1);
  localparam logic [CW-1:0] LOAD_AT    = CW'(FRAME_CLOCKS - 1);
  localparam logic [CW-1:0] SHIFT_LAST = CW'(SHIFT_BITS);
  localparam logic [CW-1:0] COUNT_MAX  = CW'(FRAME_CLOCKS);

  logic          serClkQ;
  logic [CW-1:0] clkCount;
  logic          clearPending;
  logic          rise, fall, accept;

  assign rise   = serClk & ~serClkQ;
  assign fall   = ~serClk & serClkQ;
  assign accept = rise & (dataEn | ~HAS_ENABLE);

  always_comb begin
    strb.shiftEn = accept && (clkCount != '0) && (clkCount <= SHIFT_LAST);
    strb.loadEn  = accept && (clkCount == LOAD_AT);
    strb.clearEn = fall && clearPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serClkQ      <= 1'b0;
      clkCount     <= '0;
      clearPending <= 1'b0;
    end else begin
      serClkQ <= serClk;
      if (strb.clearEn) begin
        clkCount     <= '0;
        clearPending <= 1'b0;
      end else if (accept) begin
        if (clkCount == '0) begin
          if (serData) clkCount <= CW'(1);
        end else if (clkCount < COUNT_MAX) begin
          clkCount <= clkCount + CW'(1);
        end
        if (strb.loadEn) clearPending <= 1'b1;
      end
    end
  end

  // R3: the count never runs past the frame length
  p_count_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    clkCount <= COUNT_MAX);

  // R2: an idle zero never starts a frame
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clkCount == '0 && !serData) |=> clkCount == '0);

  // R4: clearing returns the counter to idle
  p_clear_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearEn |=> (clkCount == '0 && !clearPending));

  // R8: gated edges produce no strobes
  p_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_ENABLE && !dataEn) |-> (!strb.shiftEn && !strb.loadEn));
endmodule

// File: rtl/segdrv_datapath.sv
module segdrv_datapath
  import segdrv_pkg::*;
#(
  parameter int SHIFT_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  serData,
  input  logic                  oscTick,
  input  strobes_t              strb,
  output logic [SHIFT_BITS-1:0] latchQ,
  output logic                  bpQ
);
  logic [SHIFT_BITS-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      latchQ <= '0;
      bpQ    <= 1'b0;
    end else begin
      if (strb.clearEn)      shiftQ <= '0;
      else if (strb.shiftEn) shiftQ <= {serData, shiftQ[SHIFT_BITS-1:1]};
      if (strb.loadEn) latchQ <= shiftQ;
      if (oscTick)     bpQ    <= ~bpQ;
    end
  end

  // R7: latches change only on a load
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> $stable(latchQ));

  // R4: the shifter is empty after a clear
  p_shift_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearEn |=> shiftQ == '0);

  // R9: one toggle per tick, none otherwise
  p_bp_toggle_r9: assert property (@(posedge clk) disable iff (!rstN)
    oscTick |=> bpQ != $past(bpQ));
  p_bp_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !oscTick |=> $stable(bpQ));
endmodule

// File: rtl/serial_seg_driver.sv
module serial_seg_driver
  import segdrv_pkg::*;
#(
  parameter int SEG_COUNT    = 32,
  parameter int FRAME_CLOCKS = 36,
  parameter bit HAS_ENABLE   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serClk,
  input  logic                 serData,
  input  logic                 dataEn,
  input  logic                 oscTick,
  output logic [SEG_COUNT-1:0] segOut,
  output logic                 extraSeg
);
  localparam int SHIFT_BITS = SEG_COUNT + (HAS_ENABLE ? 0 : 1);

  strobes_t              strb;
  logic [SHIFT_BITS-1:0] latchQ;
  logic                  bpQ;

  segdrv_ctrl #(
    .FRAME_CLOCKS(FRAME_CLOCKS),
    .SHIFT_BITS  (SHIFT_BITS),
    .HAS_ENABLE  (HAS_ENABLE)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serData(serData),
    .dataEn (dataEn),
    .strb   (strb)
  );

  segdrv_datapath #(
    .SHIFT_BITS(SHIFT_BITS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .serData(serData),
    .oscTick(oscTick),
    .strb   (strb),
    .latchQ (latchQ),
    .bpQ    (bpQ)
  );

  assign segOut = latchQ[SEG_COUNT-1:0] ^ {SEG_COUNT{bpQ}};

  generate
    if (HAS_ENABLE) begin : g_bpOut
      assign extraSeg = bpQ;
    end else begin : g_extraSeg
      assign extraSeg = latchQ[SHIFT_BITS-1] ^ bpQ;
    end
  endgenerate
endmodule

// File: tb/serial_seg_driver_tb.sv
module serial_seg_driver_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClkA = 1'b0, serDataA = 1'b0, dataEnA = 1'b1;
  logic serClkB = 1'b0, serDataB = 1'b0;
  logic oscTick = 1'b0;
  logic [31:0] segA, segB;
  logic extraA, extraB;

  int checks = 0;
  int errors = 0;
  logic [31:0] expA = '0;
  logic [32:0] expB = '0;
  logic bpExp = 1'b0;

  always #2 clk = ~clk;

  serial_seg_driver u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClkA), .serData(serDataA),
    .dataEn(dataEnA), .oscTick(oscTick), .segOut(segA), .extraSeg(extraA));

  serial_seg_driver #(.HAS_ENABLE(1'b0)) u_dut33 (
    .clk(clk), .rstN(rstN), .serClk(serClkB), .serData(serDataB),
    .dataEn(1'b0), .oscTick(oscTick), .segOut(segB), .extraSeg(extraB));

  function automatic logic [32:0] drive33(input logic [32:0] lat, input logic bp);
    return lat ^ {33{bp}};
  endfunction

  task automatic checkEq(input logic [32:0] act, input logic [32:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkA(input string tag);
    checkEq({1'b0, segA}, {1'b0, expA ^ {32{bpExp}}}, tag);
    checkEq({32'b0, extraA}, {32'b0, bpExp}, tag);
  endtask

  task automatic checkB(input string tag);
    checkEq({extraB, segB}, drive33(expB, bpExp), tag);
  endtask

  task automatic serBit(input bit selB, input bit d, input bit en);
    @(negedge clk);
    if (selB) serDataB = d; else begin serDataA = d; dataEnA = en; end
    @(negedge clk);
    if (selB) serClkB = 1'b1; else serClkA = 1'b1;
    repeat (2) @(negedge clk);
    if (selB) serClkB = 1'b0; else serClkA = 1'b0;
    @(negedge clk);
  endtask

  // clock index i (0 = start bit) of a frame carrying bits
  function automatic bit frameBit(input logic [32:0] bits, input int i);
    if (i == 0) return 1'b1;
    if (i <= 33) return bits[i-1];
    return 1'b0;
  endfunction

  task automatic sendClocks(input bit selB, input logic [32:0] bits, input int first, input int last);
    for (int i = first; i <= last; i++) serBit(selB, frameBit(bits, i), 1'b1);
  endtask

  task automatic tick();
    @(negedge clk); oscTick = 1'b1;
    @(negedge clk); oscTick = 1'b0;
    bpExp = ~bpExp;
    @(negedge clk);
  endtask

  initial begin
    logic [32:0] pat;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    checkA("R1 reset A");
    checkB("R1 reset B");

    // R9/R10 backplane phase with blank latches
    tick();
    checkA("R9 backplane after one tick");
    checkEq({1'b0, segA}, {1'b0, 32'hFFFF_FFFF}, "R10 off segments follow backplane");
    repeat (20) @(negedge clk);
    checkA("R9 backplane holds without ticks");

    // R6 bit 1 maps to segOut[0]
    pat = 33'h0_0000_0001;
    sendClocks(1'b0, pat, 0, 35);
    expA = pat[31:0];
    checkA("R6 first data bit to segment 0");
    pat = 33'h0_8000_0000;
    sendClocks(1'b0, pat, 0, 35);
    expA = pat[31:0];
    checkA("R6 last data bit to segment 31");

    // R3 no load before clock 36, load on its rising edge
    pat = 33'h0_A5C3_0F96;
    sendClocks(1'b0, pat, 0, 34);
    checkA("R3 unchanged after 35 clocks");
    @(negedge clk); serDataA = 1'b0;
    @(negedge clk); serClkA = 1'b1;
    repeat (2) @(negedge clk);
    expA = pat[31:0];
    checkA("R3 loaded on rising edge of clock 36");
    serClkA = 1'b0;
    @(negedge clk);

    // R5 incomplete frame survives a pause
    pat = 33'h0_1234_5678;
    sendClocks(1'b0, pat, 0, 19);
    repeat (200) @(negedge clk);
    checkA("R5 no load on short frame");
    tick();
    checkA("R10 polarity with backplane low");
    sendClocks(1'b0, pat, 20, 35);
    expA = pat[31:0];
    checkA("R5 frame completes after pause");

    // R8 gated clocks ignored (start-looking data while disabled)
    for (int i = 0; i < 12; i++) serBit(1'b0, 1'b1, 1'b0);
    checkA("R8 gated clocks change nothing");
    pat = 33'h0_0F0F_3C3C;
    sendClocks(1'b0, pat, 0, 35);
    expA = pat[31:0];
    checkA("R8 framing intact after gated clocks");

    // R2 idle zeros before the start bit
    for (int i = 0; i < 7; i++) serBit(1'b0, 1'b0, 1'b1);
    checkA("R2 idle zeros load nothing");
    pat = 33'h1_F00D_BEEF;
    sendClocks(1'b0, pat, 0, 35);
    expA = pat[31:0];
    checkA("R2 frame after idle zeros");

    // R7 identical frame: outputs steady throughout
    for (int i = 0; i <= 35; i++) begin
      serBit(1'b0, frameBit(pat, i), 1'b1);
      if (i % 6 == 5) checkA("R7 held during identical frame");
    end

    // R4 back-to-back random frames
    for (int f = 0; f < 24; f++) begin
      pat = {$urandom_range(1, 0) == 1, $urandom()};
      sendClocks(1'b0, pat, 0, 35);
      expA = pat[31:0];
      checkA("R4 back-to-back random frame");
      if ($urandom_range(3, 0) == 0) begin
        tick();
        checkA("R10 random frame other phase");
      end
    end

    // R11 variant without enable, 33 data bits
    pat = 33'h1_0000_0000;
    sendClocks(1'b1, pat, 0, 35);
    expB = pat;
    checkB("R11 33rd bit drives extra segment");
    for (int f = 0; f < 6; f++) begin
      pat = {$urandom_range(1, 0) == 1, $urandom()};
      sendClocks(1'b1, pat, 0, 34);
      checkB("R11 no load before clock 36");
      sendClocks(1'b1, pat, 35, 35);
      expB = pat;
      checkB("R11 random 33-bit frame with enable low");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule